// File: doc/BRIEF.md
# SPI Shift Engine with Gray-Coded Bit Counter

This block moves one data word at a time over a four-wire serial link. It works either as the clock owner (master) or as a follower (slave). A small write port selects the role, the idle level of the serial clock, the edge on which data is captured, the bit order and slave-select gating. A write to the data register loads the transmit word. In master mode that write also starts a transfer of `DATA_W` bits. The engine generates the clock from the system clock with a fixed half-period of `HALF_DIV` cycles.

In slave mode the incoming serial clock and slave-select are resynchronised into the system clock domain. Edges are detected there. The number of bits moved so far is reported as a Gray-coded count. The count steps 0x0, 0x1, 0x3, 0x2, 0x6, 0x7, 0x5, 0x4 and ends at 0xC after eight bits. A sticky completion flag is raised when the last bit is captured. At that moment the received word appears on the read port. Software clears the flag by writing 0 to its control bit.

Top module: `spi_shift_engine`

## Requirements
- R1: After reset, done, busy, bit_gray and rd_data are all 0. The engine is in slave mode with gating off, so sck_oe is 0 and dout_oe is 1.
- R2: A write with wr_sel=0 loads the control fields from wr_data: bit0 selects master, bit1 is the clock idle level, bit2 selects trailing-edge capture, bit3 selects LSB-first, bit4 enables slave-select gating. These fields are ignored while busy is 1.
- R3: In master mode, a write with wr_sel=1 while idle starts a transfer and busy reads 1 on the next cycle. The first sck_o edge comes HALF_DIV cycles after the write edge. sck_o then toggles every HALF_DIV cycles for 2*DATA_W edges and ends at the idle level, which equals bit1. sck_oe is 1 in master mode.
- R4: With bit2=0, din is captured on the edge that leaves the idle level, and dout moves on the return edge. With bit2=1, din is captured on the return edge, and dout moves on the leaving edge, except the first one.
- R5: With bit3=0 the most significant bit goes first on dout and fills rd_data from bit 0 upward in time. With bit3=1 the least significant bit goes first.
- R6: bit_gray equals n XOR (n>>1), where n is the number of bits captured since the last data load: 0x0, 0x1, 0x3, 0x2, 0x6, 0x7, 0x5, 0x4, 0xC.
- R7: When the DATA_W-th bit is captured, done becomes 1 and rd_data takes the received word. done stays 1 until a control write with bit7=0. A control write with bit7=1 leaves it set.
- R8: A data write while busy is 1 is ignored, and the word in flight is still sent unchanged.
- R9: In slave mode the engine follows sck_i with the same edge, order and count rules as R4 to R7. A data write while no transfer is in progress loads the transmit word and clears the count.
- R10: In slave mode with bit4=1 and ss_n_i high, dout_oe is 0 and sck_i edges leave the count unchanged. With bit4=0, ss_n_i has no effect and dout_oe is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 selects the control register, 1 selects the data register |
| wr_data | input | DATA_W | Write data |
| rd_data | output | DATA_W | Last received word |
| bit_gray | output | CW | Gray-coded count of bits captured |
| done | output | 1 | Sticky transfer-complete flag |
| busy | output | 1 | Transfer in progress |
| sck_i | input | 1 | Serial clock input (slave mode) |
| sck_o | output | 1 | Serial clock output (master mode) |
| sck_oe | output | 1 | Serial clock output enable |
| ss_n_i | input | 1 | Active-low slave select |
| din_i | input | 1 | Serial data input |
| dout_o | output | 1 | Serial data output |
| dout_oe | output | 1 | Serial data output enable |

## Verification
In master mode every capture, shift and count update lands on the same system clock edge that toggles sck_o. That edge comes HALF_DIV cycles after the previous one, or after the starting write. The bench watches sck_o at each falling system clock edge and logs dout_o and bit_gray in the half cycle right after a toggle. It changes din_i only after the shift edges, so din_i is stable well before the next capture. In slave mode a pin change takes effect three rising edges later: two synchroniser stages and one edge register. The bench holds each sck_i level for eight cycles and reads dout_o at the end of a level. It checks rd_data, done and the count only after the last edge has settled.

// File: rtl/spi_eng_pkg.sv
package spi_eng_pkg;

   // control register bit positions (software visible)
   localparam int CTL_MASTER = 0;
   localparam int CTL_CPOL   = 1;
   localparam int CTL_CPHA   = 2;
   localparam int CTL_LSBF   = 3;
   localparam int CTL_GATE   = 4;
   localparam int CTL_DONE   = 7;

   typedef struct packed {
      logic lsb_first;
      logic ss_gate;
      logic cpha;
      logic cpol;
      logic master;
   } spi_mode_t;

endpackage

// File: rtl/spi_eng_sync.sv
module spi_eng_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] pipe;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe <= {STAGES{RST_VAL}};
      else        pipe <= {pipe[STAGES-2:0], d};
   end

   assign q = pipe[STAGES-1];
endmodule

// File: rtl/spi_eng_regs.sv
module spi_eng_regs
   import spi_eng_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      wr_en,
   input  logic      wr_sel,
   input  spi_mode_t ctl_wr,
   input  logic      done_wr,
   input  logic      busy,
   input  logic      xfer_end,
   output spi_mode_t mode_q,
   output logic      done_q,
   output logic      load,
   output logic      start
);
   logic ctl_write;

   assign ctl_write = wr_en && !wr_sel;
   assign load      = wr_en && wr_sel && !busy;
   assign start     = load && mode_q.master;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mode_q <= '0;
      else if (ctl_write && !busy) mode_q <= ctl_wr;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   done_q <= 1'b0;
      else if (xfer_end)            done_q <= 1'b1;
      else if (ctl_write && !done_wr) done_q <= 1'b0;
   end
endmodule

// File: rtl/spi_eng_clkgen.sv
module spi_eng_clkgen #(
   parameter int DATA_W   = 8,
   parameter int HALF_DIV = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic cpol,
   output logic sck,
   output logic run,
   output logic lead_ev,
   output logic trail_ev
);
   localparam int EDGES = 2 * DATA_W;
   localparam int EW    = $clog2(EDGES + 1);
   localparam int DW    = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

   logic [DW-1:0] div_q;
   logic [EW-1:0] edge_q;
   logic          phase_q;
   logic          tick;

   assign tick     = run && (div_q == DW'(HALF_DIV - 1));
   assign lead_ev  = tick && !phase_q;
   assign trail_ev = tick && phase_q;
   assign sck      = cpol ^ phase_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run     <= 1'b0;
         div_q   <= '0;
         edge_q  <= '0;
         phase_q <= 1'b0;
      end else if (start) begin
         run     <= 1'b1;
         div_q   <= '0;
         edge_q  <= '0;
         phase_q <= 1'b0;
      end else if (tick) begin
         div_q   <= '0;
         phase_q <= !phase_q;
         edge_q  <= edge_q + 1'b1;
         if (edge_q == EW'(EDGES - 1)) run <= 1'b0;
      end else if (run) begin
         div_q <= div_q + 1'b1;
      end
   end
endmodule

// File: rtl/spi_eng_shift.sv
module spi_eng_shift #(
   parameter int DATA_W = 8,
   localparam int CW    = $clog2(DATA_W + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [DATA_W-1:0] load_data,
   input  logic              sample_ev,
   input  logic              shift_ev,
   input  logic              din,
   input  logic              lsb_first,
   output logic              dout,
   output logic [CW-1:0]     cnt_gray,
   output logic [DATA_W-1:0] rd_data,
   output logic              xfer_end,
   output logic              cnt_busy
);
   logic [DATA_W-1:0] tx_q, rx_q, rx_next, tx_next;
   logic [CW-1:0]     cnt_q;

   assign rx_next  = lsb_first ? {din, rx_q[DATA_W-1:1]} : {rx_q[DATA_W-2:0], din};
   assign tx_next  = lsb_first ? (tx_q >> 1) : (tx_q << 1);
   assign dout     = lsb_first ? tx_q[0] : tx_q[DATA_W-1];
   assign xfer_end = sample_ev && (cnt_q == CW'(DATA_W - 1));
   assign cnt_busy = (cnt_q != '0) && (cnt_q != CW'(DATA_W));
   assign cnt_gray = cnt_q ^ (cnt_q >> 1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_q    <= '0;
         rx_q    <= '0;
         rd_data <= '0;
         cnt_q   <= '0;
      end else if (load) begin
         tx_q  <= load_data;
         cnt_q <= '0;
      end else begin
         if (sample_ev) begin
            rx_q  <= rx_next;
            cnt_q <= (cnt_q == CW'(DATA_W)) ? CW'(1) : cnt_q + 1'b1;
            if (xfer_end) rd_data <= rx_next;
         end
         if (shift_ev && cnt_q != '0) tx_q <= tx_next;
      end
   end
endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine
   import spi_eng_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int HALF_DIV    = 2,
   parameter int SYNC_STAGES = 2,
   localparam int CW         = $clog2(DATA_W + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              wr_sel,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] rd_data,
   output logic [CW-1:0]     bit_gray,
   output logic              done,
   output logic              busy,
   input  logic              sck_i,
   output logic              sck_o,
   output logic              sck_oe,
   input  logic              ss_n_i,
   input  logic              din_i,
   output logic              dout_o,
   output logic              dout_oe
);
   // elaboration-time parameter checks
   if (DATA_W < 8) begin : g_bad_width
      $error("DATA_W must be at least 8: control bits reach bit 7");
   end
   if (HALF_DIV < 1) begin : g_bad_div
      $error("HALF_DIV must be at least 1");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   spi_mode_t mode_q, ctl_wr;
   logic      load, start, xfer_end, cnt_busy;
   logic      gen_run, gen_lead, gen_trail;
   logic      sck_s, ss_s, sck_prev;
   logic      slv_lead, slv_trail, slv_block, sck_chg;
   logic      lead_ev, trail_ev, sample_ev, shift_ev;

   assign ctl_wr = '{master:    wr_data[CTL_MASTER],
                     cpol:      wr_data[CTL_CPOL],
                     cpha:      wr_data[CTL_CPHA],
                     lsb_first: wr_data[CTL_LSBF],
                     ss_gate:   wr_data[CTL_GATE]};

   assign busy = mode_q.master ? gen_run : cnt_busy;

   spi_eng_regs u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .wr_sel   (wr_sel),
      .ctl_wr   (ctl_wr),
      .done_wr  (wr_data[CTL_DONE]),
      .busy     (busy),
      .xfer_end (xfer_end),
      .mode_q   (mode_q),
      .done_q   (done),
      .load     (load),
      .start    (start)
   );

   spi_eng_clkgen #(.DATA_W(DATA_W), .HALF_DIV(HALF_DIV)) u_clkgen (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .cpol     (mode_q.cpol),
      .sck      (sck_o),
      .run      (gen_run),
      .lead_ev  (gen_lead),
      .trail_ev (gen_trail)
   );

   spi_eng_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_sck (
      .clk (clk), .rst_n (rst_n), .d (sck_i), .q (sck_s)
   );

   spi_eng_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_ss (
      .clk (clk), .rst_n (rst_n), .d (ss_n_i), .q (ss_s)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sck_prev <= 1'b0;
      else        sck_prev <= sck_s;
   end

   assign sck_chg   = sck_s != sck_prev;
   assign slv_block = mode_q.master || (mode_q.ss_gate && ss_s);
   assign slv_lead  = !slv_block && sck_chg && (sck_s != mode_q.cpol);
   assign slv_trail = !slv_block && sck_chg && (sck_s == mode_q.cpol);

   assign lead_ev   = mode_q.master ? gen_lead  : slv_lead;
   assign trail_ev  = mode_q.master ? gen_trail : slv_trail;
   assign sample_ev = mode_q.cpha ? trail_ev : lead_ev;
   assign shift_ev  = mode_q.cpha ? lead_ev  : trail_ev;

   spi_eng_shift #(.DATA_W(DATA_W)) u_shift (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (load),
      .load_data (wr_data),
      .sample_ev (sample_ev),
      .shift_ev  (shift_ev),
      .din       (din_i),
      .lsb_first (mode_q.lsb_first),
      .dout      (dout_o),
      .cnt_gray  (bit_gray),
      .rd_data   (rd_data),
      .xfer_end  (xfer_end),
      .cnt_busy  (cnt_busy)
   );

   assign sck_oe  = mode_q.master;
   assign dout_oe = mode_q.master || !(mode_q.ss_gate && ss_n_i);
endmodule

// File: rtl/spi_shift_engine_chk.sv
module spi_shift_engine_chk #(
   parameter int DATA_W = 8,
   parameter int CW     = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              master,
   input logic              cpol,
   input logic              gate,
   input logic              busy,
   input logic              sck_o,
   input logic [CW-1:0]     bit_gray,
   input logic              done,
   input logic              wr_en,
   input logic              wr_sel,
   input logic              clr_bit,
   input logic              ss_s,
   input logic [DATA_W-1:0] rd_data,
   input logic              xfer_end
);
   localparam int GEND = DATA_W ^ (DATA_W >> 1);

   AST_SCK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (master && !busy) |-> (sck_o == cpol)); // R3

   AST_GRAY_ONE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
      ((bit_gray != $past(bit_gray)) && (bit_gray != '0) && ($past(bit_gray) != CW'(GEND)))
      |-> ($countones(bit_gray ^ $past(bit_gray)) == 1)); // R6

   AST_DONE_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> (bit_gray == CW'(GEND))); // R7

   AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !(wr_en && !wr_sel && !clr_bit)) |=> done); // R7

   AST_RX_ON_END: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_data != $past(rd_data)) |-> $past(xfer_end)); // R7

   AST_GATED_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
      (!master && gate && ss_s && !wr_en) |=> $stable(bit_gray)); // R10
endmodule

bind spi_shift_engine spi_shift_engine_chk #(.DATA_W(DATA_W), .CW(CW)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .master   (mode_q.master),
   .cpol     (mode_q.cpol),
   .gate     (mode_q.ss_gate),
   .busy     (busy),
   .sck_o    (sck_o),
   .bit_gray (bit_gray),
   .done     (done),
   .wr_en    (wr_en),
   .wr_sel   (wr_sel),
   .clr_bit  (wr_data[spi_eng_pkg::CTL_DONE]),
   .ss_s     (ss_s),
   .rd_data  (rd_data),
   .xfer_end (xfer_end)
);

// File: tb/spi_shift_engine_tb_top.sv
`timescale 1ns/1ps
module spi_shift_engine_tb_top;
   localparam int DW = 8;
   localparam int HD = 2;
   localparam int H  = 8;   // slave half-period in clk cycles

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0, wr_sel = 1'b0;
   logic [DW-1:0] wr_data = '0;
   logic [DW-1:0] rd_data;
   logic [3:0]    bit_gray;
   logic          done, busy, sck_o, sck_oe, dout_o, dout_oe;
   logic          sck_i = 1'b0, ss_n_i = 1'b1;
   logic          din_m, din_s = 1'b0, slave_sel = 1'b0;
   logic          din_i;

   int checks = 0, fails = 0;
   bit finished = 0;

   always #2 clk = ~clk;   // 250 MHz

   assign din_i = slave_sel ? din_s : din_m;

   spi_shift_engine #(.DATA_W(DW), .HALF_DIV(HD), .SYNC_STAGES(2)) dut_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
      .rd_data(rd_data), .bit_gray(bit_gray), .done(done), .busy(busy),
      .sck_i(sck_i), .sck_o(sck_o), .sck_oe(sck_oe), .ss_n_i(ss_n_i),
      .din_i(din_i), .dout_o(dout_o), .dout_oe(dout_oe)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   function automatic logic ordbit(input logic [DW-1:0] v, input logic lsb, input int i);
      return lsb ? v[i] : v[DW-1-i];
   endfunction

   function automatic logic [7:0] mkctl(input logic m, cpol, cpha, lsb, gate, keep);
      return {keep, 2'b00, gate, lsb, cpha, cpol, m};
   endfunction

   task automatic wr(input logic sel, input logic [DW-1:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_sel = sel; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   // ---------- master-side model of the far device ----------
   logic          m_cpol, m_cpha, m_lsb, mon_arm = 1'b0;
   logic [DW-1:0] m_rx;
   logic          sck_last;
   int            m_idx;
   logic          obs [DW];
   logic [3:0]    gray_log [1:DW];

   always @(negedge clk) begin
      if (mon_arm) begin
         m_idx    = 0;
         sck_last = sck_o;
         din_m    = ordbit(m_rx, m_lsb, 0);
      end else begin
         if (sck_o !== sck_last) begin
            if ((sck_o != m_cpol) != m_cpha) begin   // capture edge
               if (m_idx < DW) begin
                  obs[m_idx] = dout_o;
                  m_idx++;
                  gray_log[m_idx] = bit_gray;
               end
            end else if (m_idx > 0 && m_idx < DW) begin
               din_m = ordbit(m_rx, m_lsb, m_idx);
            end
         end
         sck_last = sck_o;
      end
   end

   task automatic arm(input logic cpol, cpha, lsb, input logic [DW-1:0] rx);
      m_cpol = cpol; m_cpha = cpha; m_lsb = lsb; m_rx = rx;
      @(posedge clk); mon_arm = 1'b1;
      @(posedge clk); mon_arm = 1'b0;
   endtask

   task automatic master_results(input string tag, input logic cpol, lsb,
                                 input logic [DW-1:0] tx, rx);
      logic [DW-1:0] seen;
      int gbad;
      seen = '0; gbad = 0;
      for (int i = 0; i < DW; i++) begin
         if (lsb) seen[i] = obs[i]; else seen[DW-1-i] = obs[i];
      end
      for (int k = 1; k <= DW; k++)
         if (gray_log[k] !== 4'(k ^ (k >> 1))) gbad++;
      check({tag, " R5 dout order"}, seen, tx);
      check({tag, " R4 rx word"}, rd_data, rx);
      check({tag, " R6 gray sequence mismatches"}, gbad, 0);
      check({tag, " R7 done set"}, done, 1);
      check({tag, " R3 idle level/busy"}, {sck_o, busy}, {cpol, 1'b0});
      check({tag, " R6 final count"}, bit_gray, 4'hC);
   endtask

   task automatic run_master(input logic cpol, cpha, lsb, input logic [DW-1:0] tx, rx);
      wr(1'b0, mkctl(1, cpol, cpha, lsb, 0, 0));
      arm(cpol, cpha, lsb, rx);
      wr(1'b1, tx);
      repeat (2 * DW * HD + 4) @(negedge clk);
      master_results("master R3", cpol, lsb, tx, rx);
   endtask

   // ---------- slave-side bench acting as master ----------
   task automatic run_slave(input logic cpol, cpha, lsb, input logic [DW-1:0] tx, rx);
      logic [DW-1:0] seen;
      seen = '0;
      wr(1'b0, mkctl(1, cpol, cpha, lsb, 1, 0));   // park in master while idling sck_i
      sck_i = cpol; ss_n_i = 1'b1;
      repeat (5) @(negedge clk);
      wr(1'b0, mkctl(0, cpol, cpha, lsb, 1, 0));
      wr(1'b1, tx);
      ss_n_i = 1'b0;
      repeat (4) @(negedge clk);
      for (int i = 0; i < DW; i++) begin
         if (!cpha) begin
            din_s = ordbit(rx, lsb, i);
            repeat (H) @(negedge clk);
            if (lsb) seen[i] = dout_o; else seen[DW-1-i] = dout_o;
            sck_i = ~cpol;
            repeat (H) @(negedge clk);
            sck_i = cpol;
         end else begin
            sck_i = ~cpol;
            din_s = ordbit(rx, lsb, i);
            repeat (H) @(negedge clk);
            if (lsb) seen[i] = dout_o; else seen[DW-1-i] = dout_o;
            sck_i = cpol;
            repeat (H) @(negedge clk);
         end
      end
      repeat (H) @(negedge clk);
      check("slave R9 dout word", seen, tx);
      check("slave R9 rx word", rd_data, rx);
      check("slave R7 done and R6 count", {done, bit_gray}, {1'b1, 4'hC});
      ss_n_i = 1'b1;
      repeat (4) @(negedge clk);
      check("slave R10 dout released", dout_oe, 0);
   endtask

   task automatic toggle_sck(input logic cpol, input int edges);
      for (int e = 0; e < edges; e++) begin
         sck_i = (e % 2 == 0) ? ~cpol : cpol;
         repeat (H) @(negedge clk);
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         checks++; fails++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      logic [DW-1:0] pats [4];
      pats[0] = 8'hA5; pats[1] = 8'h3C; pats[2] = 8'h81; pats[3] = 8'h5E;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check("R1 done/busy", {done, busy}, 2'b00);
      check("R1 count", bit_gray, 0);
      check("R1 rd_data", rd_data, 0);
      check("R1 enables", {sck_oe, dout_oe}, 2'b01);

      // R2 layout: master with cpol=1
      wr(1'b0, mkctl(1, 1, 0, 0, 0, 0));
      check("R2 master enables sck", {sck_oe, sck_o}, 2'b11);

      // exhaustive master sweep
      for (int c = 0; c < 8; c++)
         for (int p = 0; p < 4; p++)
            run_master(c[0], c[1], c[2], pats[p], {pats[p][3:0], pats[p][7:4]} ^ 8'h69);

      // R3 first edge timing, R8 busy write, R2 ctrl write ignored while busy
      wr(1'b0, mkctl(1, 0, 0, 0, 0, 0));
      arm(0, 0, 0, 8'h0F);
      wr(1'b1, 8'hC3);
      check("R3 busy after start", busy, 1);
      @(negedge clk);
      check("R3 sck before HALF_DIV", sck_o, 0);
      @(negedge clk);
      check("R3 sck first edge", sck_o, 1);
      wr(1'b1, 8'h00);                              // R8 ignored
      wr(1'b0, mkctl(1, 1, 1, 1, 0, 0));            // R2 ignored while busy
      repeat (2 * DW * HD + 4) @(negedge clk);
      master_results("R8 busy write", 0, 0, 8'hC3, 8'h0F);

      // R7 done clearing
      wr(1'b0, mkctl(1, 0, 0, 0, 0, 1));
      check("R7 write 1 keeps done", done, 1);
      wr(1'b0, mkctl(1, 0, 0, 0, 0, 0));
      check("R7 write 0 clears done", done, 0);

      // slave sweep
      slave_sel = 1'b1;
      for (int c = 0; c < 8; c++)
         for (int p = 0; p < 2; p++)
            run_slave(c[0], c[1], c[2], pats[p+1], ~pats[p]);

      // R10 gating: ss_n high with gating on blocks clocks and dout
      wr(1'b0, mkctl(1, 0, 0, 0, 1, 0));
      sck_i = 1'b0; ss_n_i = 1'b1;
      repeat (5) @(negedge clk);
      wr(1'b0, mkctl(0, 0, 0, 0, 1, 0));
      wr(1'b1, 8'h77);
      check("R10 gated dout_oe", dout_oe, 0);
      toggle_sck(0, 2 * DW);
      repeat (4) @(negedge clk);
      check("R10 gated count frozen", {done, bit_gray}, 5'h00);
      wr(1'b0, mkctl(0, 0, 0, 0, 0, 0));
      check("R10 ungated dout_oe", dout_oe, 1);
      toggle_sck(0, 4);
      repeat (4) @(negedge clk);
      check("R10 ungated counts R6", bit_gray, 4'h3);
      toggle_sck(0, 2 * DW - 4);
      repeat (4) @(negedge clk);
      check("R10 ungated completes R7", {done, bit_gray}, {1'b1, 4'hC});

      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule